// File: doc/BRIEF.md
# I2C Byte-Step Master Controller

This block is an I2C bus master that a CPU steps through a transfer one bus event at a time. The CPU works through a small byte-wide register window: a data register, a control register, a status register that shares its offset with a write-only clock setting, and a soft-reset strobe. Each time the engine completes a START, a repeated START, an address byte or a data byte, it posts a status code, raises the interrupt flag and holds SCL low. It then waits until the CPU has read the code, loaded the next byte or set a command bit, and cleared the flag.

Both bus lines are open-drain. The block drives `scl_drive_low` and `sda_drive_low` and reads the resolved wire levels back on `scl_in` and `sda_in`. Master transmit and master receive use 7-bit addresses. A STOP ends a transfer without raising the flag. If the bus shows a low level while the master is sending a 1, the master gives up the bus and reports arbitration loss.

Top module: `i2c_step_master`

## Requirements
- R1: After reset the control register reads 00h and the status register reads F8h. Both line drivers are released and `irq` is low. Register offsets are: 0 data, 1 control, 2 status on read and clock setting on write, 3 soft reset on write. Control bits are: 7 interrupt enable, 6 enable, 5 start request, 4 stop request, 3 flag, 2 acknowledge enable. Bits 1:0 read 0.
- R2: When enable is 1, the start request is 1 and the flag is 0 while the engine is idle, the engine makes SDA fall while SCL is high. It then clears the start request, sets the flag and posts code 08h.
- R3: The status register shows the 5-bit code in bits 7:3 and zeros in bits 2:0. The address byte is taken from the data register and shifted out MSB first, with bit 0 as the read/write bit. The code posted after it is 18h (write, ACK), 20h (write, NACK), 40h (read, ACK) or 48h (read, NACK).
- R4: A transmitted data byte goes out MSB first and posts 28h if the slave acknowledges it or 30h if not.
- R5: A received byte is captured MSB first into the data register. During the acknowledge pulse the master drives SDA low only when acknowledge enable is 1. The code posted is 50h if ACK was sent and 58h if NACK was sent.
- R6: While the flag is set and the code is not 38h, SCL is held low and the status code does not change.
- R7: A start request made while the flag is cleared after a byte produces a repeated START and code 10h. An address byte may follow it.
- R8: A stop request made when the flag is cleared produces a STOP, in which SDA rises while SCL is high. The stop request then clears itself, the flag stays 0 and the status becomes F8h.
- R9: If the master releases SDA to send a 1 during an address or data bit and samples SDA low, it releases both lines, posts 38h and sets the flag.
- R10: `irq` is 1 exactly when the interrupt enable bit and the flag are both 1.
- R11: The clock setting splits into M in bits 6:3 and N in bits 2:0. One SCL period lasts 10·(M+1)·2^N clock cycles.
- R12: A write to offset 3 returns all registers and the bus engine to the reset state of R1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Resolved SCL wire level |
| sda_in | input | 1 | Resolved SDA wire level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |

## Verification
The bench attaches a behavioural slave to the wired-AND bus. It aims at these faults:
- A code mapping with the ACK and NACK cases swapped posts 20h or 48h where 18h or 40h is expected.
- An address shifted out LSB first is decoded by the slave as the wrong byte.
- An acknowledge driven regardless of acknowledge enable shows up as the wrong master ACK bit seen by the slave.
- A hold state that releases SCL lets the bus run on while the flag is still set.

Arbitration loss is forced by jamming SDA during the first address bit. A design that kept driving or kept clocking fails the released-lines check. The SCL period is measured between two rising edges under two clock settings, which exposes a divider that is off by one half-period or that ignores N.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ST_A, S_ST_B, S_HOLD, S_RS_A,
    S_BIT_LO, S_BIT_HI, S_SP_A, S_SP_B, S_SP_C
  } eng_state_e;

  // status codes, five bits (shown on the bus side as code << 3)
  localparam logic [4:0] C_START   = 5'h01;
  localparam logic [4:0] C_RSTART  = 5'h02;
  localparam logic [4:0] C_AW_ACK  = 5'h03;
  localparam logic [4:0] C_AW_NACK = 5'h04;
  localparam logic [4:0] C_DW_ACK  = 5'h05;
  localparam logic [4:0] C_DW_NACK = 5'h06;
  localparam logic [4:0] C_LOST    = 5'h07;
  localparam logic [4:0] C_AR_ACK  = 5'h08;
  localparam logic [4:0] C_AR_NACK = 5'h09;
  localparam logic [4:0] C_DR_ACK  = 5'h0A;
  localparam logic [4:0] C_DR_NACK = 5'h0B;
  localparam logic [4:0] C_IDLE    = 5'h1F;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_SRST = 2'd3;

  typedef struct packed {
    logic ien;
    logic enab;
    logic sta;
    logic stp;
    logic aak;
  } ctrl_t;

endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int AW    = 2,
  parameter int DW    = 8,
  parameter int CFG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output ctrl_t            ctrl,
  output logic             iflg,
  output logic [4:0]       code,
  output logic [CFG_W-1:0] clk_cfg,
  output logic [DW-1:0]    tx_byte,
  output logic             srst,
  input  logic             ev_valid,
  input  logic             ev_flag,
  input  logic [4:0]       ev_code,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_byte,
  input  logic             sta_clr,
  input  logic             stp_clr
);

  ctrl_t            ctrl_q, ctrl_d;
  logic             iflg_q, iflg_d;
  logic [4:0]       code_q, code_d;
  logic [DW-1:0]    data_q, data_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;

  assign srst = reg_wr && (reg_addr == AW'(A_SRST));

  always_comb begin
    ctrl_d = ctrl_q;
    iflg_d = iflg_q;
    code_d = code_q;
    data_d = data_q;
    cfg_d  = cfg_q;
    if (reg_wr) begin
      case (reg_addr)
        AW'(A_DATA): data_d = reg_wdata;
        AW'(A_CTRL): begin
          ctrl_d.ien  = reg_wdata[7];
          ctrl_d.enab = reg_wdata[6];
          ctrl_d.sta  = reg_wdata[5];
          ctrl_d.stp  = reg_wdata[4];
          ctrl_d.aak  = reg_wdata[2];
          iflg_d      = iflg_q & reg_wdata[3];
        end
        AW'(A_STAT): cfg_d = reg_wdata[CFG_W-1:0];
        default: ;
      endcase
    end
    if (rx_valid) data_d = rx_byte;
    if (sta_clr)  ctrl_d.sta = 1'b0;
    if (stp_clr)  ctrl_d.stp = 1'b0;
    if (ev_valid) begin
      code_d = ev_code;
      if (ev_flag) iflg_d = 1'b1;
    end
    if (srst) begin
      ctrl_d = '0;
      iflg_d = 1'b0;
      code_d = C_IDLE;
      data_d = '0;
      cfg_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      iflg_q <= 1'b0;
      code_q <= C_IDLE;
      data_q <= '0;
      cfg_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      iflg_q <= iflg_d;
      code_q <= code_d;
      data_q <= data_d;
      cfg_q  <= cfg_d;
    end
  end

  always_comb begin
    case (reg_addr)
      AW'(A_DATA): reg_rdata = data_q;
      AW'(A_CTRL): reg_rdata = DW'({ctrl_q.ien, ctrl_q.enab, ctrl_q.sta, ctrl_q.stp,
                                    iflg_q, ctrl_q.aak, 2'b00});
      AW'(A_STAT): reg_rdata = DW'({code_q, 3'b000});
      default:     reg_rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign iflg    = iflg_q;
  assign code    = code_q;
  assign clk_cfg = cfg_q;
  assign tx_byte = data_q;

endmodule

// File: rtl/i2cm_baud.sv
module i2cm_baud #(
  parameter int M_W = 4,
  parameter int N_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               run,
  input  logic [M_W+N_W-1:0] cfg,
  output logic               tick
);

  localparam int CNT_W = M_W + (1 << N_W) + 3;

  logic [CNT_W-1:0] base, half, cnt_q, cnt_d;
  logic [M_W-1:0]   m_val;
  logic [N_W-1:0]   n_val;

  assign m_val = cfg[M_W+N_W-1:N_W];
  assign n_val = cfg[N_W-1:0];

  // half period = (M+1) * 2^N * 5 clocks
  always_comb begin
    base = (CNT_W'(m_val) + CNT_W'(1)) << n_val;
    half = (base << 2) + base;
  end

  assign tick = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || cnt_q == '0) cnt_d = half - CNT_W'(1);
    else                     cnt_d = cnt_q - CNT_W'(1);
    if (srst) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          tick,
  output logic          run,
  input  logic          sda_in,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  input  logic          iflg,
  input  logic          enab,
  input  logic          sta,
  input  logic          stp,
  input  logic          aak,
  input  logic [DW-1:0] tx_byte,
  output logic          ev_valid,
  output logic          ev_flag,
  output logic [4:0]    ev_code,
  output logic          rx_valid,
  output logic [DW-1:0] rx_byte,
  output logic          sta_clr,
  output logic          stp_clr
);

  localparam int BC_W = $clog2(DW + 1);

  eng_state_e      state_q, state_d;
  logic [BC_W-1:0] bit_q, bit_d;
  logic [DW-1:0]   sh_q, sh_d;
  logic            sda_q, sda_d;
  logic            is_addr_q, is_addr_d;
  logic            rd_q, rd_d;
  logic            rx_q, rx_d;
  logic            pend_q, pend_d;
  logic            rep_q, rep_d;
  logic            ack_q, ack_d;

  assign run           = (state_q != S_IDLE) && (state_q != S_HOLD);
  assign scl_drive_low = (state_q == S_HOLD) || (state_q == S_RS_A) ||
                         (state_q == S_BIT_LO) || (state_q == S_SP_A);
  assign sda_drive_low = sda_q;
  assign rx_byte       = sh_q;

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    sda_d     = sda_q;
    is_addr_d = is_addr_q;
    rd_d      = rd_q;
    rx_d      = rx_q;
    pend_d    = pend_q;
    rep_d     = rep_q;
    ack_d     = ack_q;
    ev_valid  = 1'b0;
    ev_flag   = 1'b0;
    ev_code   = C_IDLE;
    rx_valid  = 1'b0;
    sta_clr   = 1'b0;
    stp_clr   = 1'b0;

    case (state_q)
      S_IDLE: begin
        sda_d = 1'b0;
        if (enab && sta && !iflg) begin
          state_d = S_ST_A;
          rep_d   = 1'b0;
        end else if (stp) begin
          stp_clr = 1'b1;
        end
      end
      S_ST_A: begin
        sda_d = 1'b0;
        if (tick) begin
          state_d = S_ST_B;
          sda_d   = 1'b1;
        end
      end
      S_ST_B: begin
        if (tick) begin
          state_d  = S_HOLD;
          ev_valid = 1'b1;
          ev_flag  = 1'b1;
          ev_code  = rep_q ? C_RSTART : C_START;
          sta_clr  = 1'b1;
          pend_d   = 1'b1;
        end
      end
      S_HOLD: begin
        if (!iflg) begin
          if (sta) begin
            state_d = S_RS_A;
            sda_d   = 1'b0;
            rep_d   = 1'b1;
          end else if (stp) begin
            state_d = S_SP_A;
            sda_d   = 1'b1;
          end else begin
            state_d = S_BIT_LO;
            bit_d   = '0;
            if (pend_q) begin
              sh_d      = tx_byte;
              is_addr_d = 1'b1;
              rx_d      = 1'b0;
              rd_d      = tx_byte[0];
              sda_d     = ~tx_byte[DW-1];
            end else if (rd_q) begin
              is_addr_d = 1'b0;
              rx_d      = 1'b1;
              sda_d     = 1'b0;
            end else begin
              sh_d      = tx_byte;
              is_addr_d = 1'b0;
              rx_d      = 1'b0;
              sda_d     = ~tx_byte[DW-1];
            end
          end
        end
      end
      S_BIT_LO: begin
        if (tick) state_d = S_BIT_HI;
      end
      S_BIT_HI: begin
        if (tick) begin
          if (bit_q == BC_W'(DW)) begin
            // acknowledge bit finished
            state_d  = S_HOLD;
            sda_d    = 1'b0;
            ev_valid = 1'b1;
            ev_flag  = 1'b1;
            if (is_addr_q) begin
              pend_d = 1'b0;
              if (rd_q) ev_code = sda_in ? C_AR_NACK : C_AR_ACK;
              else       ev_code = sda_in ? C_AW_NACK : C_AW_ACK;
            end else if (rx_q) begin
              rx_valid = 1'b1;
              ev_code  = ack_q ? C_DR_ACK : C_DR_NACK;
            end else begin
              ev_code = sda_in ? C_DW_NACK : C_DW_ACK;
            end
          end else if (!rx_q && !sda_q && !sda_in) begin
            // sent a 1 but the wire is low: give the bus away
            state_d  = S_IDLE;
            sda_d    = 1'b0;
            pend_d   = 1'b0;
            ev_valid = 1'b1;
            ev_flag  = 1'b1;
            ev_code  = C_LOST;
          end else begin
            state_d = S_BIT_LO;
            bit_d   = bit_q + BC_W'(1);
            if (rx_q) sh_d = {sh_q[DW-2:0], sda_in};
            else      sh_d = {sh_q[DW-2:0], 1'b0};
            if (bit_q == BC_W'(DW - 1)) begin
              sda_d = rx_q ? aak : 1'b0;
              ack_d = aak;
            end else begin
              sda_d = rx_q ? 1'b0 : ~sh_q[DW-2];
            end
          end
        end
      end
      S_RS_A: begin
        if (tick) state_d = S_ST_A;
      end
      S_SP_A: begin
        if (tick) state_d = S_SP_B;
      end
      S_SP_B: begin
        if (tick) begin
          state_d = S_SP_C;
          sda_d   = 1'b0;
        end
      end
      S_SP_C: begin
        if (tick) begin
          state_d  = S_IDLE;
          rd_d     = 1'b0;
          ev_valid = 1'b1;
          ev_code  = C_IDLE;
          stp_clr  = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase

    if (srst) begin
      state_d   = S_IDLE;
      bit_d     = '0;
      sh_d      = '0;
      sda_d     = 1'b0;
      is_addr_d = 1'b0;
      rd_d      = 1'b0;
      rx_d      = 1'b0;
      pend_d    = 1'b0;
      rep_d     = 1'b0;
      ack_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      sda_q     <= 1'b0;
      is_addr_q <= 1'b0;
      rd_q      <= 1'b0;
      rx_q      <= 1'b0;
      pend_q    <= 1'b0;
      rep_q     <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      bit_q     <= bit_d;
      sh_q      <= sh_d;
      sda_q     <= sda_d;
      is_addr_q <= is_addr_d;
      rd_q      <= rd_d;
      rx_q      <= rx_d;
      pend_q    <= pend_d;
      rep_q     <= rep_d;
      ack_q     <= ack_d;
    end
  end

endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
  import i2cm_pkg::*;
#(
  parameter int AW  = 2,
  parameter int DW  = 8,
  parameter int M_W = 4,
  parameter int N_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_drive_low,
  output logic          sda_drive_low
);

  localparam int CFG_W = M_W + N_W;

  logic [1:0]       rs_q;
  logic             rst_n_s;
  ctrl_t            ctrl;
  logic             iflg_w, sta_w, stp_w;
  logic [4:0]       code_w;
  logic [CFG_W-1:0] cfg_w;
  logic [DW-1:0]    tx_byte, rx_byte;
  logic             srst, tick, run;
  logic             ev_valid, ev_flag, rx_valid, sta_clr, stp_clr;
  logic [4:0]       ev_code;
  logic             scl_unused;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  i2cm_regs #(.AW(AW), .DW(DW), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctrl(ctrl), .iflg(iflg_w), .code(code_w), .clk_cfg(cfg_w), .tx_byte(tx_byte),
    .srst(srst), .ev_valid(ev_valid), .ev_flag(ev_flag), .ev_code(ev_code),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .sta_clr(sta_clr), .stp_clr(stp_clr)
  );

  i2cm_baud #(.M_W(M_W), .N_W(N_W)) u_baud (
    .clk(clk), .rst_n(rst_n_s), .srst(srst), .run(run), .cfg(cfg_w), .tick(tick)
  );

  i2cm_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n_s), .srst(srst), .tick(tick), .run(run),
    .sda_in(sda_in), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .iflg(iflg_w), .enab(ctrl.enab), .sta(ctrl.sta), .stp(ctrl.stp), .aak(ctrl.aak),
    .tx_byte(tx_byte), .ev_valid(ev_valid), .ev_flag(ev_flag), .ev_code(ev_code),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .sta_clr(sta_clr), .stp_clr(stp_clr)
  );

  assign sta_w      = ctrl.sta;
  assign stp_w      = ctrl.stp;
  assign irq        = ctrl.ien & iflg_w;
  assign scl_unused = scl_in;

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
  import i2cm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       iflg,
  input logic       sta,
  input logic       stp,
  input logic [4:0] code,
  input logic       scl_oe,
  input logic       sda_oe
);

  // R6: bus frozen with SCL low while a step awaits service
  p_hold_scl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && code != C_LOST) |-> scl_oe);

  // R2: start request consumed when the START report is posted
  p_start_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(iflg) && code == C_START) |-> !sta);

  // R8: entering the idle code never raises the flag and consumes stop
  p_stop_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code == C_IDLE) |-> (!iflg && !stp));

  // R9: lost arbitration leaves both lines released
  p_lost_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && code == C_LOST) |-> (!scl_oe && !sda_oe));

  // R3: every raised flag carries a real event code
  p_flag_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflg) |-> (code != C_IDLE));

endmodule

bind i2c_step_master i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_n_s), .iflg(iflg_w), .sta(sta_w), .stp(stp_w),
  .code(code_w), .scl_oe(scl_drive_low), .sda_oe(sda_drive_low)
);

// File: tb/test_i2c_step_master.sv
`timescale 1ns/1ps
module test_i2c_step_master;

  logic       clk;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       scl_drive_low, sda_drive_low;
  logic       scl_bus, sda_bus;
  logic       s_low, jam;

  int n_cmp = 0;
  int n_bad = 0;

  assign scl_bus = ~scl_drive_low;
  assign sda_bus = ~(sda_drive_low | s_low | jam);

  i2c_step_master i_i2c_step_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- behavioural slave (address 5Ah) ----------------
  localparam logic [6:0] SLV = 7'h5A;
  logic [7:0] rd_buf [2];
  logic [7:0] got_addr, wlog, sh, cur;
  logic       active, in_addr, rd, mack, nack_data, prev_scl, prev_sda;
  int         bitn, idx, cyc, last_rise, prev_rise;

  initial begin
    rd_buf[0] = 8'hA7; rd_buf[1] = 8'h3E;
    s_low = 0; jam = 0; nack_data = 0; active = 0; in_addr = 0; rd = 0; mack = 0;
    bitn = 0; idx = 0; cyc = 0; last_rise = 0; prev_rise = 0;
    got_addr = 0; wlog = 0; sh = 0; cur = 0; prev_scl = 1; prev_sda = 1;
    forever begin
      @(negedge clk);
      cyc++;
      if (scl_bus && prev_scl && prev_sda && !sda_bus) begin
        active = 1; in_addr = 1; bitn = 0; rd = 0; s_low = 0;
      end else if (scl_bus && prev_scl && !prev_sda && sda_bus) begin
        active = 0; s_low = 0;
      end else if (!prev_scl && scl_bus) begin
        prev_rise = last_rise; last_rise = cyc;
        if (active) begin
          if (bitn < 8) sh = {sh[6:0], sda_bus};
          else mack = sda_bus;
          bitn++;
        end
      end else if (prev_scl && !scl_bus && active) begin
        if (bitn == 8) begin
          if (in_addr) begin
            got_addr = sh;
            if (sh[7:1] == SLV) begin s_low = 1; rd = sh[0]; idx = 0; end
            else begin s_low = 0; active = 0; end
          end else if (!rd) begin
            wlog = sh; s_low = !nack_data;
          end else s_low = 0;
        end else if (bitn == 9) begin
          bitn = 0;
          if (in_addr) begin
            in_addr = 0;
            if (rd) begin cur = rd_buf[0]; s_low = !cur[7]; end else s_low = 0;
          end else if (rd && !mack) begin
            idx = (idx + 1) % 2; cur = rd_buf[idx]; s_low = !cur[7];
          end else begin
            s_low = 0; if (rd) active = 0;
          end
        end else if (bitn >= 1 && bitn <= 7 && rd && !in_addr) begin
          s_low = !cur[7 - bitn];
        end
      end
      prev_scl = scl_bus; prev_sda = sda_bus;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_flag(input string tag);
    logic [7:0] c;
    for (int i = 0; i < 20000; i++) begin
      rd_reg(2'd1, c);
      if (c[3]) return;
    end
    chk({tag, " flag timeout"}, 0, 1);
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] c;
    for (int i = 0; i < 20000; i++) begin
      rd_reg(2'd2, c);
      if (c == 8'hF8) return;
    end
    chk({tag, " idle timeout"}, 0, 1);
  endtask

  task automatic status_is(input string tag, input logic [7:0] exp);
    logic [7:0] s;
    rd_reg(2'd2, s);
    chk(tag, s, exp);
  endtask

  task automatic do_stop();
    wr(2'd1, 8'h50);
    wait_idle("stop");
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [7:0] v;
    rd_reg(2'd1, v); chk("R1 control reset", v, 8'h00);
    rd_reg(2'd2, v); chk("R1 status reset", v, 8'hF8);
    chk("R1 irq reset", irq, 0);
    chk("R1 lines released", {scl_bus, sda_bus}, 2'b11);
  endtask

  task automatic t_write();
    logic [7:0] v;
    wr(2'd1, 8'h60);
    wait_flag("R2");
    status_is("R2 start code", 8'h08);
    rd_reg(2'd1, v); chk("R2 sta cleared flag set", v, 8'h48);
    chk("R10 irq low with ien 0", irq, 0);
    repeat (40) @(negedge clk);
    chk("R6 scl held low", scl_bus, 0);
    status_is("R6 code stable", 8'h08);
    wr(2'd0, 8'hB4); wr(2'd1, 8'h40);
    wait_flag("R3");
    status_is("R3 addr write ack", 8'h18);
    chk("R3 address msb first", got_addr, 8'hB4);
    chk("R11 default period", last_rise - prev_rise, 10);
    wr(2'd0, 8'h3C); wr(2'd1, 8'h40);
    wait_flag("R4");
    status_is("R4 data ack", 8'h28);
    chk("R4 data msb first", wlog, 8'h3C);
    nack_data = 1;
    wr(2'd0, 8'h81); wr(2'd1, 8'h40);
    wait_flag("R4");
    status_is("R4 data nack", 8'h30);
    nack_data = 0;
    do_stop();
    rd_reg(2'd1, v); chk("R8 stp self-clear no flag", v, 8'h40);
    chk("R8 lines released after stop", {scl_bus, sda_bus}, 2'b11);
  endtask

  task automatic t_addr_nack();
    wr(2'd1, 8'h60); wait_flag("R3");
    wr(2'd0, 8'h22); wr(2'd1, 8'h40);
    wait_flag("R3");
    status_is("R3 addr write nack", 8'h20);
    do_stop();
  endtask

  task automatic t_read();
    logic [7:0] v;
    wr(2'd1, 8'h64); wait_flag("R5");
    wr(2'd0, 8'hB5); wr(2'd1, 8'h44);
    wait_flag("R3");
    status_is("R3 addr read ack", 8'h40);
    wr(2'd1, 8'h44);
    wait_flag("R5");
    status_is("R5 rx with ack", 8'h50);
    rd_reg(2'd0, v); chk("R5 rx byte 0", v, 8'hA7);
    chk("R5 master ack driven", mack, 0);
    wr(2'd1, 8'h40);
    wait_flag("R5");
    status_is("R5 rx with nack", 8'h58);
    rd_reg(2'd0, v); chk("R5 rx byte 1", v, 8'h3E);
    chk("R5 master nack released", mack, 1);
    do_stop();
  endtask

  task automatic t_read_nack();
    wr(2'd1, 8'h60); wait_flag("R3");
    wr(2'd0, 8'h23); wr(2'd1, 8'h40);
    wait_flag("R3");
    status_is("R3 addr read nack", 8'h48);
    do_stop();
  endtask

  task automatic t_repeated();
    wr(2'd1, 8'h60); wait_flag("R7");
    wr(2'd0, 8'hB4); wr(2'd1, 8'h40); wait_flag("R7");
    wr(2'd1, 8'h60);
    wait_flag("R7");
    status_is("R7 repeated start", 8'h10);
    wr(2'd0, 8'hB5); wr(2'd1, 8'h44);
    wait_flag("R7");
    status_is("R7 read after restart", 8'h40);
    do_stop();
  endtask

  task automatic t_arb();
    wr(2'd1, 8'hE0); wait_flag("R9");
    chk("R10 irq with ien and flag", irq, 1);
    jam = 1;
    wr(2'd0, 8'hB4); wr(2'd1, 8'hC0);
    wait_flag("R9");
    status_is("R9 lost code", 8'h38);
    chk("R9 drivers released", {scl_drive_low, sda_drive_low}, 2'b00);
    wr(2'd1, 8'h40);
    @(negedge clk);
    chk("R10 irq drops with flag", irq, 0);
    jam = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_rate(input logic [7:0] cfg, input int period);
    wr(2'd2, cfg);
    wr(2'd1, 8'h60); wait_flag("R11");
    wr(2'd0, 8'hB4); wr(2'd1, 8'h40); wait_flag("R11");
    chk("R11 scl period", last_rise - prev_rise, period);
    do_stop();
    wr(2'd2, 8'h00);
  endtask

  task automatic t_srst();
    logic [7:0] v;
    wr(2'd1, 8'hE0); wait_flag("R12");
    wr(2'd3, 8'h00);
    @(negedge clk);
    rd_reg(2'd1, v); chk("R12 control cleared", v, 8'h00);
    rd_reg(2'd2, v); chk("R12 status idle", v, 8'hF8);
    chk("R12 irq low", irq, 0);
    chk("R12 lines released", {scl_drive_low, sda_drive_low}, 2'b00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; reg_addr = 0; reg_wr = 0; reg_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_addr_nack();
    t_read();
    t_read_nack();
    t_repeated();
    t_arb();
    t_rate(8'h11, 60);
    t_rate(8'h08, 20);
    t_srst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule